// File: doc/BRIEF.md
# Scan Self-Test Sequencer for Delay Faults

This block runs a test-per-scan self-test session on a scanned logic core. When software or a test controller pulses `start`, it applies a programmed number of patterns. Each pattern is pseudo-random data shifted into the scan chains, a pseudo-random vector on the core's primary inputs, and an at-speed launch and capture. The data shifted out of the chains is folded into a signature register. A single `done` flag marks the end of the session, and `signature` holds the compacted result, which is compared against a known-good value elsewhere.

Two at-speed sequences are supported. In the shift-launch sequence, the last shift cycle itself creates the transition, and one capture pulse follows with scan enable low. In the capture-launch sequence, scan enable drops after the last shift and two functional pulses follow: the first launches and the second captures. Three small shift registers with linear feedback produce the data: one for the primary-input vector, one for the serial scan data, and one that counts shift cycles in place of a binary counter. Each of them, and the signature register, can be built with feedback outside the register (external XOR) or between its stages (internal XOR) through a parameter. Internal XOR is the default.

Top module: `sbist_ctrl`

## Requirements
- R1: After reset, `scan_en`, `cap_en`, `scan_in` and `done` are low, `signature` is zero and `pi_vec` holds the input-vector seed 0xA5.
- R2: During every shift cycle, `scan_in` equals the two low bits of an 8-bit scan-data generator. The generator is reloaded with 0x3C when `start` is accepted and advances once per shift cycle. Its step is a left shift, with the mask 0x1D XORed in when the bit shifted out is 1. Outside shift cycles `scan_in` is zero.
- R3: Every shift burst lasts exactly CHAIN_LEN (default 8) consecutive cycles of `scan_en` high. The length is counted by a 4-bit feedback counter that is restarted from a fixed seed at the beginning of each burst.
- R4: In shift-launch mode (`mode`=1), each load burst is followed immediately by exactly one cycle with `cap_en` high and `scan_en` low. The next burst then starts at once.
- R5: In capture-launch mode (`mode`=0), each load burst is followed by exactly two consecutive cycles with `cap_en` high and `scan_en` low.
- R6: `cap_en` and `scan_en` are never high in the same cycle.
- R7: `pi_vec` is reloaded to 0xA5 when a session starts. It advances one step after each capture cycle that ends a pattern, and is stable otherwise. The step is a left shift, with the mask 0x2D XORed in when the bit shifted out is 1.
- R8: `signature` is cleared when a session starts and changes only on shift cycles that unload captured data: every burst except the first. On such a cycle it becomes a left shift with 0x71 XORed in when the bit shifted out is 1, further XORed with `scan_out` in bits [1:0].
- R9: After `pat_total` patterns, one further unload burst runs. Then `done` rises and stays high, with `signature` unchanged, until the next `start`.
- R10: With `pat_total` = 0, `done` is high in the cycle after `start` and `signature` is zero.
- R11: `start`, `mode` and `pat_total` are sampled only when a session starts. Changes to them while a session runs have no effect.
- R12: A `start` while `done` is high begins a fresh session, with all generators reseeded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a session when idle or done |
| mode | input | 1 | 1 = launch by last shift, 0 = launch by capture pulse |
| pat_total | input | 8 | Number of patterns in the session |
| scan_out | input | 2 | Serial data returning from the scan chains |
| scan_en | output | 1 | Scan enable for the chains |
| scan_in | output | 2 | Serial data driven into the scan chains |
| pi_vec | output | 8 | Pseudo-random primary-input vector |
| cap_en | output | 1 | Enable for a functional (launch or capture) clock pulse |
| signature | output | 8 | Compacted response signature |
| done | output | 1 | Session complete |

## Verification
On every cycle the assertions check the following. Shift bursts have exact length, and a capture pulse follows each burst. Capture pulses come in runs of at most two. The primary-input vector stays stable within a burst. The signature stays frozen outside shift cycles, and the completed state is held. Other behaviour can only be shown by the scenarios, whose per-cycle expectations come from independent models of the generators and the signature register. These cover the choice between one and two capture pulses, the exact scan data and vector values, which bursts feed the signature, the zero-pattern session, and that a `start` or mode change in mid-session has no effect.

// File: rtl/sbist_pkg.sv
package sbist_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SHIFT  = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_CAPT   = 3'd3,
        ST_DONE   = 3'd4
    } seq_st_e;
endpackage

// File: rtl/sbist_lfsr.sv
module sbist_lfsr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = 8'h1D,
    parameter logic [W-1:0] SEED = 8'h01,
    parameter bit           FIB  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] st_d, st_q, nxt;

    generate
        if (FIB) begin : g_ext
            assign nxt = {st_q[W-2:0], st_q[W-1] ^ (^(st_q[W-2:0] & MASK[W-1:1]))};
        end else begin : g_int
            assign nxt = {st_q[W-2:0], 1'b0} ^ (st_q[W-1] ? MASK : '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load)      st_d = SEED;
        else if (step) st_d = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED;
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/sbist_misr.sv
module sbist_misr #(
    parameter int           W    = 8,
    parameter int           IN_W = 2,
    parameter logic [W-1:0] MASK = 8'h71,
    parameter bit           FIB  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [IN_W-1:0] din,
    output logic [W-1:0]    sig
);
    logic [W-1:0] sig_d, sig_q, nxt, din_ext;

    always_comb begin
        din_ext = '0;
        din_ext[IN_W-1:0] = din;
    end

    generate
        if (FIB) begin : g_ext
            assign nxt = {sig_q[W-2:0], sig_q[W-1] ^ (^(sig_q[W-2:0] & MASK[W-1:1]))} ^ din_ext;
        end else begin : g_int
            assign nxt = ({sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? MASK : '0)) ^ din_ext;
        end
    endgenerate

    always_comb begin
        sig_d = sig_q;
        if (clr)     sig_d = '0;
        else if (en) sig_d = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig = sig_q;
endmodule

// File: rtl/sbist_fsm.sv
module sbist_fsm
    import sbist_pkg::*;
#(
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode,
    input  logic [PAT_W-1:0] pat_total,
    input  logic             cnt_last,
    output logic             cnt_load,
    output logic             cnt_step,
    output logic             gen_load,
    output logic             dat_step,
    output logic             pi_step,
    output logic             misr_clr,
    output logic             misr_en,
    output logic             scan_en,
    output logic             cap_en,
    output logic             done
);
    typedef struct packed {
        seq_st_e          st;
        logic [PAT_W-1:0] pat;
        logic [PAT_W-1:0] total;
        logic             unload;
        logic             fin;
        logic             los;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        cnt_load = 1'b0;
        cnt_step = 1'b0;
        gen_load = 1'b0;
        dat_step = 1'b0;
        pi_step  = 1'b0;
        misr_clr = 1'b0;
        misr_en  = 1'b0;
        unique case (s_q.st)
            ST_IDLE, ST_DONE: begin
                // R11: session parameters sampled only here
                if (start) begin
                    s_d.los    = mode;
                    s_d.total  = pat_total;
                    s_d.pat    = '0;
                    s_d.unload = 1'b0;
                    s_d.fin    = 1'b0;
                    cnt_load   = 1'b1;
                    gen_load   = 1'b1;
                    misr_clr   = 1'b1;
                    s_d.st     = (pat_total == '0) ? ST_DONE : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                dat_step = 1'b1;
                misr_en  = s_q.unload;
                if (cnt_last) begin
                    if (s_q.fin)      s_d.st = ST_DONE;
                    else if (s_q.los) s_d.st = ST_CAPT;
                    else              s_d.st = ST_LAUNCH;
                end else begin
                    cnt_step = 1'b1;
                end
            end
            ST_LAUNCH: s_d.st = ST_CAPT;
            ST_CAPT: begin
                s_d.pat    = s_q.pat + 1'b1;
                s_d.unload = 1'b1;
                s_d.fin    = ((s_q.pat + 1'b1) == s_q.total);
                pi_step    = 1'b1;
                cnt_load   = 1'b1;
                s_d.st     = ST_SHIFT;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign scan_en = (s_q.st == ST_SHIFT);
    assign cap_en  = (s_q.st == ST_LAUNCH) || (s_q.st == ST_CAPT);
    assign done    = (s_q.st == ST_DONE);
endmodule

// File: rtl/sbist_ctrl.sv
module sbist_ctrl #(
    parameter int               CHAINS    = 2,
    parameter int               CHAIN_LEN = 8,
    parameter int               PAT_W     = 8,
    parameter int               PI_W      = 8,
    parameter int               DAT_W     = 8,
    parameter int               SIG_W     = 8,
    parameter int               CNT_W     = 4,
    parameter logic [PI_W-1:0]  PI_MASK   = 8'h2D,
    parameter logic [PI_W-1:0]  PI_SEED   = 8'hA5,
    parameter logic [DAT_W-1:0] DAT_MASK  = 8'h1D,
    parameter logic [DAT_W-1:0] DAT_SEED  = 8'h3C,
    parameter logic [SIG_W-1:0] SIG_MASK  = 8'h71,
    parameter logic [CNT_W-1:0] CNT_MASK  = 4'h9,
    parameter logic [CNT_W-1:0] CNT_SEED  = 4'h1,
    parameter bit               FIB       = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic [PAT_W-1:0]  pat_total,
    input  logic [CHAINS-1:0] scan_out,
    output logic              scan_en,
    output logic [CHAINS-1:0] scan_in,
    output logic [PI_W-1:0]   pi_vec,
    output logic              cap_en,
    output logic [SIG_W-1:0]  signature,
    output logic              done
);
    // R3: terminal state of the shift counter after CHAIN_LEN-1 steps
    function automatic logic [CNT_W-1:0] cnt_term();
        logic [CNT_W-1:0] s;
        s = CNT_SEED;
        for (int i = 0; i < CHAIN_LEN - 1; i++) begin
            if (FIB) s = {s[CNT_W-2:0], s[CNT_W-1] ^ (^(s[CNT_W-2:0] & CNT_MASK[CNT_W-1:1]))};
            else     s = {s[CNT_W-2:0], 1'b0} ^ (s[CNT_W-1] ? CNT_MASK : '0);
        end
        return s;
    endfunction

    localparam logic [CNT_W-1:0] CNT_TERM = cnt_term();

    logic             cnt_load, cnt_step, gen_load, dat_step, pi_step;
    logic             misr_clr, misr_en, cnt_last;
    logic [CNT_W-1:0] cnt_q;
    logic [DAT_W-1:0] dat_q;

    assign cnt_last = (cnt_q == CNT_TERM);

    sbist_fsm #(.PAT_W(PAT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mode     (mode),
        .pat_total(pat_total),
        .cnt_last (cnt_last),
        .cnt_load (cnt_load),
        .cnt_step (cnt_step),
        .gen_load (gen_load),
        .dat_step (dat_step),
        .pi_step  (pi_step),
        .misr_clr (misr_clr),
        .misr_en  (misr_en),
        .scan_en  (scan_en),
        .cap_en   (cap_en),
        .done     (done)
    );

    sbist_lfsr #(.W(CNT_W), .MASK(CNT_MASK), .SEED(CNT_SEED), .FIB(FIB)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .step(cnt_step), .state(cnt_q)
    );

    sbist_lfsr #(.W(DAT_W), .MASK(DAT_MASK), .SEED(DAT_SEED), .FIB(FIB)) u_dat (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(dat_step), .state(dat_q)
    );

    sbist_lfsr #(.W(PI_W), .MASK(PI_MASK), .SEED(PI_SEED), .FIB(FIB)) u_pi (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .step(pi_step), .state(pi_vec)
    );

    sbist_misr #(.W(SIG_W), .IN_W(CHAINS), .MASK(SIG_MASK), .FIB(FIB)) u_misr (
        .clk(clk), .rst_n(rst_n), .clr(misr_clr), .en(misr_en), .din(scan_out), .sig(signature)
    );

    assign scan_in = scan_en ? dat_q[CHAINS-1:0] : '0;
endmodule

// File: rtl/sbist_chk.sv
module sbist_chk #(
    parameter int CHAIN_LEN = 8,
    parameter int PI_W      = 8,
    parameter int SIG_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             scan_en,
    input logic             cap_en,
    input logic             done,
    input logic [PI_W-1:0]  pi_vec,
    input logic [SIG_W-1:0] signature
);
    logic [15:0] run_q;
    logic [1:0]  cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            cap_q <= '0;
        end else begin
            run_q <= scan_en ? run_q + 16'd1 : '0;
            cap_q <= cap_en ? ((cap_q == 2'd3) ? cap_q : cap_q + 2'd1) : '0;
        end
    end

    p_shift_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |-> (run_q < 16'(CHAIN_LEN)));
    p_shift_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> (run_q == 16'(CHAIN_LEN)));
    p_cap_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scan_en) && !done) |-> cap_en);
    p_cap_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> (cap_q < 2'd2));
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en && scan_en));
    p_pi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en)) |-> $stable(pi_vec));
    p_sig_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(scan_en) && !$past(start)) |-> $stable(signature));
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(signature)));
endmodule

bind sbist_ctrl sbist_chk #(.CHAIN_LEN(CHAIN_LEN), .PI_W(PI_W), .SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_en(scan_en), .cap_en(cap_en),
    .done(done), .pi_vec(pi_vec), .signature(signature)
);

// File: tb/tb_sbist_ctrl.sv
module tb_sbist_ctrl;
    localparam int CLK_PER = 10;
    localparam int L       = 8;
    localparam logic [7:0] PI_SEED = 8'hA5, PI_MASK = 8'h2D;
    localparam logic [7:0] DAT_SEED = 8'h3C, DAT_MASK = 8'h1D;
    localparam logic [7:0] SIG_MASK = 8'h71;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
    logic [7:0] pat_total = '0;
    logic [1:0] scan_out = '0;
    logic       scan_en, cap_en, done;
    logic [1:0] scan_in;
    logic [7:0] pi_vec, signature;

    int n_tests = 0, n_fail = 0;
    logic [7:0] last_pi = PI_SEED, last_sig = '0;

    typedef struct {
        logic se, ce, dn, chk_sig;
        logic [1:0] si, so;
        logic [7:0] pi, sig;
        string tag;
    } item_t;
    item_t q[$];

    always #(CLK_PER/2) clk = ~clk;

    sbist_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pat_total(pat_total),
        .scan_out(scan_out), .scan_en(scan_en), .scan_in(scan_in), .pi_vec(pi_vec),
        .cap_en(cap_en), .signature(signature), .done(done)
    );

    function automatic logic [7:0] step8(input logic [7:0] s, input logic [7:0] m);
        return {s[6:0], 1'b0} ^ (s[7] ? m : 8'h00);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per cycle
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            scan_out = it.so;
            chk(scan_en === it.se, it.tag, "scan_en", 32'(scan_en), 32'(it.se));
            chk(cap_en === it.ce, it.tag, "cap_en (R6)", 32'(cap_en), 32'(it.ce));
            chk(scan_in === it.si, {it.tag, " R2"}, "scan_in", 32'(scan_in), 32'(it.si));
            chk(pi_vec === it.pi, {it.tag, " R7"}, "pi_vec", 32'(pi_vec), 32'(it.pi));
            chk(done === it.dn, {it.tag, " R9"}, "done", 32'(done), 32'(it.dn));
            if (it.chk_sig)
                chk(signature === it.sig, {it.tag, " R8"}, "signature", 32'(signature), 32'(it.sig));
        end
    end

    function automatic item_t mk(input logic se, ce, dn, input logic [1:0] si, so,
                                 input logic [7:0] pi, input bit cs, input logic [7:0] sg,
                                 input string tag);
        item_t it;
        it.se = se; it.ce = ce; it.dn = dn; it.si = si; it.so = so;
        it.pi = pi; it.chk_sig = cs; it.sig = sg; it.tag = tag;
        return it;
    endfunction

    // driver: computes expected per-cycle behaviour and starts a session
    task automatic run_seq(input logic los, input int npat, input bit poke, input string tag);
        logic [7:0] pi = PI_SEED, dat = DAT_SEED, sig = 8'h00;
        logic [1:0] so;
        int k = 0;
        @(negedge clk);
        start = 1'b1; mode = los; pat_total = 8'(npat);
        @(posedge clk);
        if (npat == 0) begin
            q.push_back(mk(0, 0, 1, 2'b00, 2'b00, pi, 1, 8'h00, {tag, " R10"}));
        end else begin
            for (int p = 0; p <= npat; p++) begin
                for (int s = 0; s < L; s++) begin
                    so = 2'((k * 3) ^ (k >> 2) ^ p);
                    q.push_back(mk(1, 0, 0, dat[1:0], so, pi, 0, 8'h00, {tag, " R3"}));
                    if (p > 0) sig = step8(sig, SIG_MASK) ^ {6'b0, so};
                    dat = step8(dat, DAT_MASK);
                    k++;
                end
                if (p < npat) begin
                    q.push_back(mk(0, 1, 0, 2'b00, 2'b00, pi, 0, 8'h00, los ? {tag, " R4"} : {tag, " R5"}));
                    if (!los)
                        q.push_back(mk(0, 1, 0, 2'b00, 2'b00, pi, 0, 8'h00, {tag, " R5"}));
                    pi = step8(pi, PI_MASK);
                end
            end
            q.push_back(mk(0, 0, 1, 2'b00, 2'b00, pi, 1, sig, {tag, " R9"}));
        end
        last_pi = pi; last_sig = sig;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (4) @(negedge clk);
            start = 1'b1; mode = ~los; pat_total = 8'd0;
            @(negedge clk);
            start = 1'b0;
        end
        wait (q.size() == 0);
        @(posedge clk);
    endtask

    // done hold with start low
    task automatic hold(input int n);
        @(posedge clk);
        for (int i = 0; i < n; i++)
            q.push_back(mk(0, 0, 1, 2'b00, 2'b00, last_pi, 1, last_sig, "R9 hold"));
        wait (q.size() == 0);
        @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scan_en === 1'b0, "R1", "scan_en", 32'(scan_en), 0);
        chk(cap_en === 1'b0, "R1", "cap_en", 32'(cap_en), 0);
        chk(scan_in === 2'b00, "R1", "scan_in", 32'(scan_in), 0);
        chk(done === 1'b0, "R1", "done", 32'(done), 0);
        chk(signature === 8'h00, "R1", "signature", 32'(signature), 0);
        chk(pi_vec === PI_SEED, "R1", "pi_vec", 32'(pi_vec), 32'(PI_SEED));

        run_seq(1'b1, 3, 1'b0, "R4 shift-launch");
        hold(3);
        run_seq(1'b0, 2, 1'b1, "R11 capture-launch poked R12");
        run_seq(1'b0, 0, 1'b0, "R10 zero patterns");
        run_seq(1'b1, 1, 1'b1, "R11 R12 single");
        run_seq(1'b0, 4, 1'b0, "R5 four patterns");
        hold(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule